// File: doc/BRIEF.md
# Strap-Addressed Serial Bus Slave Front End

This block is the bus-facing front end of a register-based peripheral on a two-wire serial management bus. A fast system clock oversamples the clock and data lines. The block finds start and stop conditions on those lines and shifts in the address byte. It answers only when the 7-bit address equals the one picked by a three-state strap. On a write it passes each received data byte to a local register-access port with a one-cycle valid strobe. On a read it asks that port for each byte just before the byte has to be shifted out.

The strap reaches the block as a 2-bit code that has already been resolved. The block reads it once, on the first start condition after reset, and keeps that address until the next reset. Moving the strap afterwards has no effect. The data line is open-drain: the block never drives it high and only asserts an output enable that pulls it low.

Top module: `smb_strap_slave`

## Requirements
- R1: The strap code selects the 7-bit address as follows: 2'b01 (tied high) selects 0x2F, 2'b00 (tied low) selects 0x2C, and 2'b10 (floating) selects 0x2E. The unused code 2'b11 is treated as floating.
- R2: The strap is captured on the first start condition after reset. Any later change on `strap_i` leaves the answered address unchanged until the next reset.
- R3: A start condition is the data line falling while the clock line is high. Every start makes the next 8 bits the address phase: the address is received MSB first and is followed by the direction bit, where 1 means read.
- R4: When the received address matches, the block pulls the data line low (`sda_oe`=1) for the whole 9th clock. When it does not match, the block leaves the line released until the next start, including through any data bytes that follow.
- R5: In a write transfer, every data byte is acknowledged. The byte appears on `wr_data` together with a one-cycle `wr_valid` pulse.
- R6: In a read transfer, `rd_req` pulses once after the address is accepted and once after each byte the master acknowledges. The byte on `rd_data` is then sent MSB first.
- R7: When the master leaves the acknowledge bit of a read byte high, the block releases the data line, raises no further `rd_req` and drives nothing until the next start.
- R8: A stop condition, which is the data line rising while the clock line is high, returns the block to idle from any phase, including partway through a byte, and releases the data line.
- R9: A repeated start in the middle of a transfer restarts the address phase directly, so a new address and direction can be accepted without an intervening stop.
- R10: The block places no limit on the number of data bytes in one transfer.
- R11: During and right after reset, `sda_oe`, `wr_valid` and `rd_req` are all 0.
- R12: `sda_oe` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired-AND level) |
| sda_oe | output | 1 | Pull the data line low when 1 |
| strap_i | input | 2 | Resolved strap code: 00 low, 01 high, 10 floating |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte, held stable after `rd_req` |

## Verification
The hardest states to reach from the ports are the ones where a bus condition arrives at an awkward time. One is a repeated start right after a write byte has been acknowledged. Another is a stop that cuts off a byte after only a few bits, in either the address phase or the data phase. The bench has a bus master model with bit-level tasks, so it can place a start or a stop between any two clock pulses. It then runs a complete transfer to show that the block went back to a clean address phase. Strap freezing is checked by moving the strap after the first transfer and showing that the old address is still the only one answered. Each strap code is checked after its own reset.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

   typedef enum logic [1:0] {
      STRAP_LOW   = 2'b00,
      STRAP_HIGH  = 2'b01,
      STRAP_FLOAT = 2'b10,
      STRAP_RSVD  = 2'b11
   } strap_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ADDR_ACK,
      PH_WR_DATA,
      PH_WR_ACK,
      PH_RD_DATA,
      PH_RD_ACK
   } phase_e;

   // Events decoded from the synchronized bus lines, valid for one cycle.
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
      logic sda;
      logic scl;
   } bus_ev_t;

endpackage

// File: rtl/smbs_line_sync.sv
module smbs_line_sync
   import smbs_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_raw,
   input  logic    sda_raw,
   output bus_ev_t ev
);

   localparam int LINES   = 2;
   localparam int IDX_SCL = 0;
   localparam int IDX_SDA = 1;

   logic [LINES-1:0] raw_vec;
   logic [LINES-1:0] cur_vec;
   logic [LINES-1:0] old_vec;

   assign raw_vec[IDX_SCL] = scl_raw;
   assign raw_vec[IDX_SDA] = sda_raw;

   if (STAGES < 2) begin : g_bad_stages
      $error("smbs_line_sync: STAGES must be at least 2");
   end

   for (genvar li = 0; li < LINES; li++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
         end else begin
            chain <= {chain[STAGES-2:0], raw_vec[li]};
            last  <= chain[STAGES-1];
         end
      end
      assign cur_vec[li] = chain[STAGES-1];
      assign old_vec[li] = last;
   end

   logic scl_now, scl_was, sda_now, sda_was;
   assign scl_now = cur_vec[IDX_SCL];
   assign scl_was = old_vec[IDX_SCL];
   assign sda_now = cur_vec[IDX_SDA];
   assign sda_was = old_vec[IDX_SDA];

   always_comb begin
      ev.scl      = scl_now;
      ev.sda      = sda_now;
      ev.scl_rise = scl_now & ~scl_was;
      ev.scl_fall = ~scl_now & scl_was;
      ev.start    = scl_now & scl_was & sda_was & ~sda_now;
      ev.stop     = scl_now & scl_was & ~sda_was & sda_now;
   end

endmodule

// File: rtl/smbs_strap_latch.sv
module smbs_strap_latch
   import smbs_pkg::*;
#(
   parameter int                ADDR_W     = 7,
   parameter logic [ADDR_W-1:0] ADDR_HIGH  = 7'h2F,
   parameter logic [ADDR_W-1:0] ADDR_LOW   = 7'h2C,
   parameter logic [ADDR_W-1:0] ADDR_FLOAT = 7'h2E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        strap,
   input  logic              start_seen,
   output logic [ADDR_W-1:0] own_addr,
   output logic              captured
);

   logic [ADDR_W-1:0] decoded;

   always_comb begin
      unique case (strap_e'(strap))
         STRAP_HIGH:  decoded = ADDR_HIGH;
         STRAP_LOW:   decoded = ADDR_LOW;
         STRAP_FLOAT: decoded = ADDR_FLOAT;
         default:     decoded = ADDR_FLOAT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr <= '0;
         captured <= 1'b0;
      end else if (start_seen && !captured) begin
         own_addr <= decoded;
         captured <= 1'b1;
      end
   end

endmodule

// File: rtl/smbs_byte_engine.sv
module smbs_byte_engine
   import smbs_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              wr_valid,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   output phase_e            phase
);

   localparam int               CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   if (ADDR_W + 1 != DATA_W) begin : g_bad_width
      $error("smbs_byte_engine: address plus direction bit must fill one byte");
   end

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic              dir_rd;
   logic              master_ack;
   logic              addr_hit;

   assign addr_hit = (rx_sh[DATA_W-1 -: ADDR_W] == own_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         bit_cnt    <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         sda_oe     <= 1'b0;
         wr_valid   <= 1'b0;
         wr_data    <= '0;
         rd_req     <= 1'b0;
         dir_rd     <= 1'b0;
         master_ack <= 1'b0;
      end else begin
         wr_valid <= 1'b0;
         rd_req   <= 1'b0;
         if (ev.start) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (ev.stop) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (phase)
               PH_ADDR, PH_WR_DATA: begin
                  if (ev.scl_rise) begin
                     rx_sh   <= {rx_sh[DATA_W-2:0], ev.sda};
                     bit_cnt <= bit_cnt + CNT_ONE;
                  end else if (ev.scl_fall && bit_cnt == CNT_FULL) begin
                     bit_cnt <= '0;
                     if (phase == PH_ADDR) begin
                        if (addr_hit) begin
                           phase  <= PH_ADDR_ACK;
                           sda_oe <= 1'b1;
                           dir_rd <= rx_sh[0];
                           rd_req <= rx_sh[0];
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end else begin
                        phase    <= PH_WR_ACK;
                        sda_oe   <= 1'b1;
                        wr_valid <= 1'b1;
                        wr_data  <= rx_sh;
                     end
                  end
               end
               PH_ADDR_ACK: begin
                  if (ev.scl_fall) begin
                     if (dir_rd) begin
                        phase  <= PH_RD_DATA;
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                     end else begin
                        phase  <= PH_WR_DATA;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               PH_WR_ACK: begin
                  if (ev.scl_fall) begin
                     phase  <= PH_WR_DATA;
                     sda_oe <= 1'b0;
                  end
               end
               PH_RD_DATA: begin
                  if (ev.scl_rise) begin
                     bit_cnt <= bit_cnt + CNT_ONE;
                  end else if (ev.scl_fall) begin
                     if (bit_cnt == CNT_FULL) begin
                        phase   <= PH_RD_ACK;
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                     end else begin
                        tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[DATA_W-2];
                     end
                  end
               end
               PH_RD_ACK: begin
                  if (ev.scl_rise) begin
                     master_ack <= ~ev.sda;
                     rd_req     <= ~ev.sda;
                  end else if (ev.scl_fall) begin
                     if (master_ack) begin
                        phase  <= PH_RD_DATA;
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
   import smbs_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 7,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] ADDR_HIGH   = 7'h2F,
   parameter logic [ADDR_W-1:0] ADDR_LOW    = 7'h2C,
   parameter logic [ADDR_W-1:0] ADDR_FLOAT  = 7'h2E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        strap_i,
   output logic              wr_valid,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   input  logic [DATA_W-1:0] rd_data
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("smb_strap_slave: SYNC_STAGES below 2 is not metastability safe");
   end
   if (ADDR_W + 1 != DATA_W) begin : g_chk_width
      $error("smb_strap_slave: DATA_W must equal ADDR_W + 1");
   end

   bus_ev_t           ev;
   logic [ADDR_W-1:0] own_addr;
   logic              strap_taken;
   phase_e            phase;
   logic              scl_s;

   assign scl_s = ev.scl;

   smbs_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_raw (scl_i),
      .sda_raw (sda_i),
      .ev      (ev)
   );

   smbs_strap_latch #(
      .ADDR_W     (ADDR_W),
      .ADDR_HIGH  (ADDR_HIGH),
      .ADDR_LOW   (ADDR_LOW),
      .ADDR_FLOAT (ADDR_FLOAT)
   ) u_strap (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap      (strap_i),
      .start_seen (ev.start),
      .own_addr   (own_addr),
      .captured   (strap_taken)
   );

   smbs_byte_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .own_addr (own_addr),
      .rd_data  (rd_data),
      .sda_oe   (sda_oe),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .rd_req   (rd_req),
      .phase    (phase)
   );

endmodule

// File: rtl/smb_strap_slave_chk.sv
module smb_strap_slave_chk
   import smbs_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_oe,
   input logic              wr_valid,
   input logic              rd_req,
   input logic              captured,
   input logic [ADDR_W-1:0] own_addr,
   input phase_e            phase
);

   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |-> (!sda_oe && !wr_valid && !rd_req));

   assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      captured |=> (captured && $stable(own_addr)));

   assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && rd_req));

   assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |=> ((phase != PH_IDLE) || !sda_oe));

   assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

endmodule

bind smb_strap_slave smb_strap_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_oe   (sda_oe),
   .wr_valid (wr_valid),
   .rd_req   (rd_req),
   .captured (strap_taken),
   .own_addr (own_addr),
   .phase    (phase)
);

// File: tb/smb_strap_slave_bench.sv
module smb_strap_slave_bench;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [1:0] strap = 2'b01;
   logic       sda_oe;
   logic       wr_valid;
   logic [7:0] wr_data;
   logic       rd_req;
   logic [7:0] rd_data = 8'h00;
   logic       sda_line;

   int tests = 0;
   int fails = 0;
   int rd_seq = 0;
   logic [7:0] wr_exp[$];
   logic [7:0] rd_exp[$];

   assign sda_line = m_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_strap_slave u_smb_strap_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .strap_i  (strap),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .rd_req   (rd_req),
      .rd_data  (rd_data)
   );

   function automatic logic [7:0] rd_pat(input int k);
      return 8'(k * 37 + 8'h5A);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Read-data provider: next byte on every request.
   always @(negedge clk) begin
      if (rst_n && rd_req) begin
         rd_seq  = rd_seq + 1;
         rd_data = rd_pat(rd_seq);
      end
   end

   // Write monitor: pops expected bytes as the design strobes them.
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (wr_exp.size() == 0) begin
            check(1'b0, "R4/R5 unexpected wr_valid", int'(wr_data), 0);
         end else begin
            logic [7:0] e;
            e = wr_exp.pop_front();
            check(wr_data == e, "R5 write byte", int'(wr_data), int'(e));
         end
      end
   end

   task automatic wait_q();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic seen);
      logic oe_a;
      m_sda = b;
      wait_q();
      m_scl = 1'b1;
      repeat (QTR/2) @(negedge clk);
      oe_a = sda_oe;
      repeat (QTR - QTR/2) @(negedge clk);
      seen = sda_line;
      wait_q();
      check(sda_oe == oe_a, "R12 sda_oe stable while clock high", int'(sda_oe), int'(oe_a));
      m_scl = 1'b0;
      wait_q();
   endtask

   task automatic bus_start();
      m_sda = 1'b1;
      wait_q();
      m_scl = 1'b1;
      wait_q();
      m_sda = 1'b0;
      wait_q();
      m_scl = 1'b0;
      wait_q();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0;
      wait_q();
      m_scl = 1'b1;
      wait_q();
      m_sda = 1'b1;
      wait_q();
   endtask

   task automatic write_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] v);
      logic s;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         bus_bit(1'b1, s);
         v = {v[6:0], s};
      end
      bus_bit(~give_ack, s);
   endtask

   task automatic do_reset(input logic [1:0] code);
      rst_n = 1'b0;
      strap = code;
      m_scl = 1'b1;
      m_sda = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic probe_addr(input logic [6:0] a, input logic expect_ack, input string req);
      logic ak;
      bus_start();
      write_byte({a, 1'b0}, ak);
      check(ak == expect_ack, req, int'(ak), int'(expect_ack));
      bus_stop();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic       ak;
      logic [7:0] v;
      logic [7:0] e;
      int         base;
      int         acks;

      do_reset(2'b01);
      check(sda_oe == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0,
            "R11 outputs quiet after reset", int'({sda_oe, wr_valid, rd_req}), 0);

      // First transfer captures the high strap (0x2F); three write bytes.
      bus_start();
      write_byte({7'h2F, 1'b0}, ak);
      check(ak, "R1/R4 high strap address acked", int'(ak), 1);
      for (int i = 0; i < 3; i++) begin
         wr_exp.push_back(8'hC3 ^ 8'(i * 17));
         write_byte(8'hC3 ^ 8'(i * 17), ak);
         check(ak, "R5 write byte acked", int'(ak), 1);
      end
      bus_stop();
      repeat (20) @(negedge clk);
      check(wr_exp.size() == 0, "R5 all write bytes strobed", wr_exp.size(), 0);

      // Strap moves to low after capture: 0x2C must stay unanswered.
      strap = 2'b00;
      bus_start();
      write_byte({7'h2C, 1'b0}, ak);
      check(!ak, "R2 late strap change ignored", int'(ak), 0);
      write_byte(8'h77, ak);
      check(!ak, "R4 data after mismatch not acked", int'(ak), 0);
      bus_stop();
      probe_addr(7'h2F, 1'b1, "R2 captured address still answered");

      // Near-miss addresses: LSB differs, MSB differs.
      probe_addr(7'h2E, 1'b0, "R3 address LSB mismatch");
      probe_addr(7'h6F, 1'b0, "R3 address MSB mismatch");

      // Read transfer: ack, ack, no-ack.
      base = rd_seq;
      bus_start();
      write_byte({7'h2F, 1'b1}, ak);
      check(ak, "R3/R6 read address acked", int'(ak), 1);
      for (int i = 1; i <= 3; i++) rd_exp.push_back(rd_pat(base + i));
      for (int i = 0; i < 3; i++) begin
         read_byte(i < 2, v);
         e = rd_exp.pop_front();
         check(v == e, "R6 read byte MSB first", int'(v), int'(e));
      end
      check(sda_oe == 1'b0, "R7 line released after no-ack", int'(sda_oe), 0);
      repeat (4 * QTR) @(negedge clk);
      check(rd_seq == base + 3, "R7 no request after no-ack", rd_seq, base + 3);
      check(sda_oe == 1'b0, "R7 still released", int'(sda_oe), 0);
      bus_stop();

      // Repeated start: write one byte, then switch to read.
      bus_start();
      write_byte({7'h2F, 1'b0}, ak);
      wr_exp.push_back(8'h11);
      write_byte(8'h11, ak);
      check(ak, "R5 byte before repeated start", int'(ak), 1);
      base = rd_seq;
      bus_start();
      write_byte({7'h2F, 1'b1}, ak);
      check(ak, "R9 repeated start address acked", int'(ak), 1);
      read_byte(1'b0, v);
      check(v == rd_pat(base + 1), "R9 read after repeated start", int'(v), int'(rd_pat(base + 1)));
      bus_stop();

      // Stop in the middle of a data byte, then in the middle of the address.
      bus_start();
      write_byte({7'h2F, 1'b0}, ak);
      bus_bit(1'b1, ak);
      bus_bit(1'b0, ak);
      bus_bit(1'b1, ak);
      bus_bit(1'b1, ak);
      bus_stop();
      repeat (10) @(negedge clk);
      check(sda_oe == 1'b0, "R8 released after mid-byte stop", int'(sda_oe), 0);
      bus_start();
      bus_bit(1'b0, ak);
      bus_bit(1'b1, ak);
      bus_bit(1'b0, ak);
      bus_stop();
      probe_addr(7'h2F, 1'b1, "R8 clean transfer after aborted address");

      // Long write transfer.
      bus_start();
      write_byte({7'h2F, 1'b0}, ak);
      acks = 0;
      for (int i = 0; i < 20; i++) begin
         wr_exp.push_back(8'(i * 7 + 3));
         write_byte(8'(i * 7 + 3), ak);
         if (ak) acks++;
      end
      bus_stop();
      repeat (20) @(negedge clk);
      check(acks == 20, "R10 twenty bytes acked", acks, 20);
      check(wr_exp.size() == 0, "R10 twenty bytes strobed", wr_exp.size(), 0);

      // Other strap codes, each after its own reset.
      do_reset(2'b00);
      probe_addr(7'h2C, 1'b1, "R1 low strap selects 0x2C");
      probe_addr(7'h2F, 1'b0, "R1 low strap rejects 0x2F");
      do_reset(2'b10);
      probe_addr(7'h2E, 1'b1, "R1 floating strap selects 0x2E");
      probe_addr(7'h2C, 1'b0, "R1 floating strap rejects 0x2C");
      do_reset(2'b11);
      probe_addr(7'h2E, 1'b1, "R1 reserved code acts as floating");

      repeat (20) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule